// File: doc/BRIEF.md
# Row-Column Pixel Read Port

This block lets a slow host read any byte of a stored frame in any order. The host presents a column, a row and a byte offset. The block turns them into a physical address in a single-port frame memory, using the configured bytes per pixel and the configured line width. It then returns the addressed byte on a 10-bit read bus. The width is held in configuration as the line width divided by four.

The frame memory is shared with the capture writer. While a capture is running, the memory address and write strobe come from the capture side. The read bus is released (high impedance) and its drive enable is low. When no capture is running, the memory address comes from the registered read address and writes are blocked.

The host inputs are not synchronised. The host lets them settle, and the result is due a fixed number of internal clock cycles later.

Top module: `pixel_read_port`

## Requirements
- R1: While reset is asserted and just after it, with no capture, `mem_addr_o` is 0, `mem_we_o` is 0, `rd_oe_o` is 1 and `rd_data_o` is 0.
- R2: With capture low, `mem_addr_o` equals bpp*col + bpp*width*row + idx one clock edge after the inputs settle.
- R3: The line width used in R2 is four times `width_q4_i`. For example, 160 gives 640.
- R4: `byte_idx_i` (0 to 3) adds its value directly to the address, so the extra bytes of multi-byte pixel formats can be reached.
- R5: An address result above 2^19-1 is clamped to 2^19-1 (all ones).
- R6: While `capture_i` is 1, `mem_addr_o` equals `cap_addr_i` and `mem_we_o` equals `cap_we_i` in the same cycle.
- R7: While `capture_i` is 0, `mem_we_o` is 0 whatever `cap_we_i` is.
- R8: While `capture_i` is 1, `rd_oe_o` is 0 and `rd_data_o` is high impedance.
- R9: With capture low, `rd_data_o` equals {2'b00, memory byte at the computed address} two clock edges after the inputs settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | internal clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| col_i | input | 10 | pixel column |
| row_i | input | 9 | pixel row |
| byte_idx_i | input | 2 | byte offset within a pixel |
| width_q4_i | input | 8 | line width divided by four |
| bpp_i | input | 8 | bytes per pixel |
| capture_i | input | 1 | a frame capture is in progress |
| cap_addr_i | input | 19 | capture writer address |
| cap_we_i | input | 1 | capture writer write strobe |
| mem_addr_o | output | 19 | frame memory address |
| mem_we_o | output | 1 | frame memory write strobe |
| mem_rdata_i | input | 8 | frame memory read data |
| rd_data_o | output | 10 | host read data, high impedance during capture |
| rd_oe_o | output | 1 | drive enable of the host read bus |

## Verification
The address result is due one rising edge after the inputs are applied, and the read data is due after a second edge. The capture-side mux and the bus release act in the same cycle, with no edge in between. Every stimulus is applied on a falling edge. Address checks wait one rising edge and sample at the following falling edge, and data checks wait one more rising edge before sampling. The memory model in the bench returns a byte that is a fixed function of the address, so a wrong address shows up as wrong data.

// File: rtl/pxrd_pkg.sv
package pxrd_pkg;
  localparam int COL_W_D  = 10;
  localparam int ROW_W_D  = 9;
  localparam int IDX_W_D  = 2;
  localparam int CFG_W_D  = 8;
  localparam int ADDR_W_D = 19;
  localparam int MEM_DW_D = 8;
  localparam int OUT_DW_D = 10;
endpackage

// File: rtl/pxrd_addr_calc.sv
module pxrd_addr_calc #(
  parameter int COL_W  = pxrd_pkg::COL_W_D,
  parameter int ROW_W  = pxrd_pkg::ROW_W_D,
  parameter int IDX_W  = pxrd_pkg::IDX_W_D,
  parameter int CFG_W  = pxrd_pkg::CFG_W_D,
  parameter int ADDR_W = pxrd_pkg::ADDR_W_D
) (
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CFG_W-1:0]  width_q4_i,
  input  logic [CFG_W-1:0]  bpp_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int WID_W = CFG_W + 2;
  localparam int PA_W  = CFG_W + COL_W;
  localparam int PB_W  = CFG_W + WID_W + ROW_W;
  localparam int SUM_W = ((PA_W > PB_W) ? PA_W : PB_W) + 1;

  logic [WID_W-1:0] width;
  logic [SUM_W-1:0] prod_col, prod_row, sum;

  assign width    = {width_q4_i, 2'b00};
  assign prod_col = SUM_W'(bpp_i) * SUM_W'(col_i);
  assign prod_row = SUM_W'(bpp_i) * SUM_W'(width) * SUM_W'(row_i);
  assign sum      = prod_col + prod_row + SUM_W'(idx_i);

  generate
    if (SUM_W > ADDR_W) begin : g_sat
      assign addr_o = (sum[SUM_W-1:ADDR_W] != '0) ? {ADDR_W{1'b1}} : sum[ADDR_W-1:0];
    end else begin : g_nosat
      assign addr_o = ADDR_W'(sum);
    end
  endgenerate
endmodule

// File: rtl/pxrd_port_mux.sv
module pxrd_port_mux #(
  parameter int ADDR_W = pxrd_pkg::ADDR_W_D
) (
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic              cap_we_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o
);
  always_comb begin
    if (capture_i) begin
      mem_addr_o = cap_addr_i;
      mem_we_o   = cap_we_i;
    end else begin
      mem_addr_o = rd_addr_i;
      mem_we_o   = 1'b0;
    end
  end
endmodule

// File: rtl/pxrd_data_stage.sv
module pxrd_data_stage #(
  parameter int MEM_DW = pxrd_pkg::MEM_DW_D,
  parameter int OUT_DW = pxrd_pkg::OUT_DW_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [MEM_DW-1:0] mem_rdata_i,
  output logic [OUT_DW-1:0] rd_data_o,
  output logic              rd_oe_o
);
  logic [MEM_DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         data_q <= '0;
    else if (!capture_i) data_q <= mem_rdata_i;
  end

  assign rd_oe_o = !capture_i;

  generate
    if (OUT_DW > MEM_DW) begin : g_pad
      assign rd_data_o = rd_oe_o ? {{(OUT_DW-MEM_DW){1'b0}}, data_q} : {OUT_DW{1'bz}};
    end else begin : g_cut
      assign rd_data_o = rd_oe_o ? data_q[OUT_DW-1:0] : {OUT_DW{1'bz}};
    end
  endgenerate
endmodule

// File: rtl/pixel_read_port.sv
module pixel_read_port #(
  parameter int COL_W  = pxrd_pkg::COL_W_D,
  parameter int ROW_W  = pxrd_pkg::ROW_W_D,
  parameter int IDX_W  = pxrd_pkg::IDX_W_D,
  parameter int CFG_W  = pxrd_pkg::CFG_W_D,
  parameter int ADDR_W = pxrd_pkg::ADDR_W_D,
  parameter int MEM_DW = pxrd_pkg::MEM_DW_D,
  parameter int OUT_DW = pxrd_pkg::OUT_DW_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic [CFG_W-1:0]  width_q4_i,
  input  logic [CFG_W-1:0]  bpp_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic              cap_we_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  input  logic [MEM_DW-1:0] mem_rdata_i,
  output logic [OUT_DW-1:0] rd_data_o,
  output logic              rd_oe_o
);
  logic [ADDR_W-1:0] calc_addr, rd_addr_q;

  pxrd_addr_calc #(
    .COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W)
  ) u_calc (
    .col_i(col_i), .row_i(row_i), .idx_i(byte_idx_i),
    .width_q4_i(width_q4_i), .bpp_i(bpp_i), .addr_o(calc_addr)
  );

  // one register stage fixes the read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_addr_q <= '0;
    else         rd_addr_q <= calc_addr;
  end

  pxrd_port_mux #(.ADDR_W(ADDR_W)) u_mux (
    .capture_i(capture_i), .rd_addr_i(rd_addr_q), .cap_addr_i(cap_addr_i),
    .cap_we_i(cap_we_i), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o)
  );

  pxrd_data_stage #(.MEM_DW(MEM_DW), .OUT_DW(OUT_DW)) u_data (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture_i),
    .mem_rdata_i(mem_rdata_i), .rd_data_o(rd_data_o), .rd_oe_o(rd_oe_o)
  );
endmodule

// File: rtl/pixel_read_port_chk.sv
module pixel_read_port_chk #(
  parameter int COL_W  = pxrd_pkg::COL_W_D,
  parameter int ROW_W  = pxrd_pkg::ROW_W_D,
  parameter int IDX_W  = pxrd_pkg::IDX_W_D,
  parameter int CFG_W  = pxrd_pkg::CFG_W_D,
  parameter int ADDR_W = pxrd_pkg::ADDR_W_D,
  parameter int OUT_DW = pxrd_pkg::OUT_DW_D
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [COL_W-1:0]  col_i,
  input logic [ROW_W-1:0]  row_i,
  input logic [IDX_W-1:0]  byte_idx_i,
  input logic [CFG_W-1:0]  width_q4_i,
  input logic [CFG_W-1:0]  bpp_i,
  input logic              capture_i,
  input logic [ADDR_W-1:0] cap_addr_i,
  input logic              cap_we_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [OUT_DW-1:0] rd_data_o,
  input logic              rd_oe_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_cap_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> (mem_addr_o == cap_addr_i && mem_we_o == cap_we_i));

  assert_no_idle_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |-> !mem_we_o);

  assert_bus_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> !rd_oe_o);

  assert_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> rd_data_o[OUT_DW-1:8] == '0);

  assert_addr_steady_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !capture_i && $stable(col_i) && $stable(row_i) && $stable(byte_idx_i)
     && $stable(width_q4_i) && $stable(bpp_i)) |=> (capture_i || $stable(mem_addr_o)));

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    (!rst_ni && !capture_i) |-> (mem_addr_o == '0 && !mem_we_o && rd_oe_o));
endmodule

bind pixel_read_port pixel_read_port_chk #(
  .COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W), .CFG_W(CFG_W),
  .ADDR_W(ADDR_W), .OUT_DW(OUT_DW)
) u_chk (.*);

// File: tb/pixel_read_port_tb_top.sv
`timescale 1ns/1ps
module pixel_read_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  col = '0;
  logic [8:0]  row = '0;
  logic [1:0]  idx = '0;
  logic [7:0]  wq4 = '0;
  logic [7:0]  bpp = '0;
  logic        cap = 1'b0;
  logic [18:0] cap_addr = '0;
  logic        cap_we = 1'b0;
  logic [18:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic [9:0]  rd_data;
  logic        rd_oe;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]};
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  pixel_read_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .col_i(col), .row_i(row), .byte_idx_i(idx),
    .width_q4_i(wq4), .bpp_i(bpp), .capture_i(cap), .cap_addr_i(cap_addr),
    .cap_we_i(cap_we), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .rd_data_o(rd_data), .rd_oe_o(rd_oe)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_addr(input int c, input int r, input int i,
                                      input int w, input int b);
    longint s = longint'(b) * c + longint'(b) * (w * 4) * r + i;
    return (s > 524287) ? 524287 : s;
  endfunction

  // apply at falling edge, address due after one rising edge, data after two
  task automatic read_px(input string req, input int c, input int r, input int i,
                         input int w, input int b);
    longint e = exp_addr(c, r, i, w, b);
    @(negedge clk);
    col = 10'(c); row = 9'(r); idx = 2'(i); wq4 = 8'(w); bpp = 8'(b);
    @(negedge clk);
    chk(req, mem_addr, e);
    @(negedge clk);
    chk("R9", rd_data, {2'b00, mem_fn(19'(e))});
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1", mem_addr, 0);
    chk("R1", mem_we, 0);
    chk("R1", rd_oe, 1);
    chk("R1", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", rd_data, 0);
  endtask

  task automatic t_linear();
    read_px("R2", 0, 0, 0, 40, 1);
    read_px("R2", 159, 0, 0, 40, 1);
    read_px("R2", 37, 119, 0, 40, 1);
    read_px("R2", 5, 3, 0, 80, 2);
  endtask

  task automatic t_width();
    read_px("R3", 0, 1, 0, 160, 2);
    read_px("R3", 639, 479, 0, 160, 1);
    read_px("R3", 10, 1, 0, 1, 1);
  endtask

  task automatic t_index();
    for (int i = 0; i < 4; i++) read_px("R4", 12, 7, i, 40, 3);
  endtask

  task automatic t_clamp();
    read_px("R5", 1023, 511, 3, 255, 255);
    read_px("R5", 0, 257, 0, 255, 2);
    read_px("R5", 511, 255, 0, 255, 2);
  endtask

  task automatic t_capture();
    longint e = exp_addr(20, 30, 1, 40, 2);
    @(negedge clk);
    col = 10'd20; row = 9'd30; idx = 2'd1; wq4 = 8'd40; bpp = 8'd2;
    cap = 1'b1; cap_addr = 19'd12345; cap_we = 1'b1;
    #1;
    chk("R6", mem_addr, 12345);
    chk("R6", mem_we, 1);
    chk("R8", rd_oe, 0);
    @(negedge clk);
    cap_addr = 19'd524287; cap_we = 1'b0;
    #1;
    chk("R6", mem_addr, 524287);
    chk("R6", mem_we, 0);
    chk("R8", rd_oe, 0);
    @(negedge clk);
    cap = 1'b0; cap_we = 1'b1;
    #1;
    chk("R7", mem_we, 0);
    chk("R2", mem_addr, e);
    chk("R8", rd_oe, 1);
    @(negedge clk);
    chk("R7", mem_we, 0);
    chk("R9", rd_data, {2'b00, mem_fn(19'(e))});
    cap_we = 1'b0;
  endtask

  initial begin
    t_reset();
    t_linear();
    t_width();
    t_index();
    t_clamp();
    t_capture();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule